// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the horizontal and vertical raster timing for a parallel LCD panel. Software loads three packed timing words and one control word through a one-cycle write port. From these words the block derives a pixel-clock enable, horizontal and vertical sync, a data-enable strobe, a frame-start flag, and the current pixel and line positions. The pixel rate is either the system clock, when the divider is bypassed, or the system clock divided by a programmable ratio.

Every line runs through four regions in a fixed order: the active pixels, then the front porch, then the sync pulse, then the back porch. Every frame runs through the same four regions, counted in lines. The line counter steps each time the pixel counter wraps, and scanning is non-interlaced. Horizontal lengths are stored minus one, and the active width is held in units of 16 pixels. The vertical porches are stored as plain line counts. The sync and data-enable outputs each have their own polarity bit.

In dual-panel operation the programmed line count covers half the screen. Both halves are scanned together. Alongside the upper-half line number, the block gives the line number of the matching row in the lower half. A control bit starts and stops scanning, and stopping returns the raster to its origin at once.

Top module: `lcdRasterGen`

## Requirements
- R1: After reset, every output is 0: pixClkEn, hSync, vSync, dataEn, frameStart, pixelCnt, lineCnt and lowerLine.
- R2: Address 2 bits [4:0] hold a divide value P, and bit 26 is a bypass. While scanning with the bypass set, pixClkEn is 1 on every cycle. With the bypass clear, pixClkEn is 1 on one cycle out of every P+2. That cycle is the (P+2)-th cycle counted from the start of scanning, and every P+2 cycles after it.
- R3: Address 0 holds the horizontal timing. Bits [7:2] hold K, bits [31:24] the front porch F, bits [15:8] the sync S and bits [23:16] the back porch B. A line has 16·(K+1) active pixels, then F+1 front-porch pixels, then S+1 sync pixels, then B+1 back-porch pixels. pixelCnt starts at 0 on the first active pixel and steps once per pixClkEn. It wraps to 0 after the last back-porch pixel.
- R4: Address 1 holds the vertical timing. Bits [9:0] hold N, bits [31:24] the front porch, bits [15:10] the sync W and bits [23:16] the back porch. A frame has N+1 active lines, then the front-porch count of lines, then W+1 sync lines, then the back-porch count of lines. The porch counts have no minus-one offset. lineCnt steps only when pixelCnt wraps, and it wraps to 0 after the last line.
- R5: While scanning, hSync is 1 during the horizontal sync pixels, and vSync is 1 during the vertical sync lines. Address 2 bit 12 inverts hSync, and address 2 bit 11 inverts vSync.
- R6: While scanning, dataEn is 1 only on an active pixel of an active line. Address 2 bit 14 inverts dataEn.
- R7: frameStart is 1 exactly while scanning with pixelCnt = 0 and lineCnt = 0. This makes it one pixel clock long, on the first active pixel of each frame.
- R8: Address 3 bit 0 is the scan enable. Writing 1 starts the raster at pixel 0 of line 0. Writing 0 takes effect on the next cycle. From then on, pixelCnt and lineCnt are 0, pixClkEn and frameStart are 0, and hSync, vSync and dataEn sit at their inactive levels (the value of their inversion bits).
- R9: Address 3 bit 1 selects dual-panel operation. In that mode lowerLine = lineCnt + N + 1. In single-panel operation lowerLine = lineCnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 horizontal, 1 vertical, 2 clock and polarity, 3 control |
| wrData | input | 32 | Register write data |
| pixClkEn | output | 1 | One-cycle pixel clock enable |
| hSync | output | 1 | Horizontal sync, polarity as programmed |
| vSync | output | 1 | Vertical sync, polarity as programmed |
| dataEn | output | 1 | Active-video strobe, polarity as programmed |
| frameStart | output | 1 | High on the first active pixel of each frame |
| pixelCnt | output | H_W | Pixel position within the line |
| lineCnt | output | V_W | Line position within the frame (upper half in dual mode) |
| lowerLine | output | V_W+1 | Lower-half line position in dual mode, else equal to lineCnt |

## Verification
Two directed setups come first. The first is a bypassed clock with true polarities in single-panel mode. The second is a divided clock with every output inverted in dual-panel mode. Between them they separate the divider path from the bypass and the inverted output levels from the true ones. Randomly drawn setups then vary the active width, each porch and sync length, the divide ratio and the mode. Every output is compared on every cycle for a little over one frame, so an error at any region boundary or at a wrap shows up. Each run ends with a mid-frame stop, which checks that the counters clear and the outputs fall to their inactive levels one cycle after the write.

// File: rtl/lcdRasterPkg.sv
package lcdRasterPkg;

  // Programmed timing fields, held in their stored (encoded) form
  typedef struct packed {
    logic [5:0] ppl;   // active width in 16-pixel units, minus one
    logic [7:0] hsw;   // horizontal sync, minus one
    logic [7:0] hbp;   // horizontal back porch, minus one
    logic [7:0] hfp;   // horizontal front porch, minus one
    logic [9:0] lpp;   // lines per panel, minus one
    logic [5:0] vsw;   // vertical sync, minus one
    logic [7:0] vbp;   // vertical back porch, plain count
    logic [7:0] vfp;   // vertical front porch, plain count
    logic       ivs;
    logic       ihs;
    logic       ioe;
    logic       dual;
  } timingT;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;   // advance raster by one pixel
    logic clear;  // force raster to origin
    logic run;    // scanning is enabled
  } strobeT;

endpackage

// File: rtl/lcdRasterCtrl.sv
module lcdRasterCtrl
  import lcdRasterPkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  output timingT      cfg,
  output strobeT      stb
);
  localparam int DC_W = DIV_W + 1;

  logic [DIV_W-1:0] divSel;
  logic             bypass;
  logic             enReg;
  logic [DC_W-1:0]  divCnt;
  logic             tick;
  logic             offWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      divSel <= '0;
      bypass <= 1'b0;
      enReg  <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0: begin
          cfg.ppl <= wrData[7:2];
          cfg.hsw <= wrData[15:8];
          cfg.hbp <= wrData[23:16];
          cfg.hfp <= wrData[31:24];
        end
        2'd1: begin
          cfg.lpp <= wrData[9:0];
          cfg.vsw <= wrData[15:10];
          cfg.vbp <= wrData[23:16];
          cfg.vfp <= wrData[31:24];
        end
        2'd2: begin
          divSel  <= wrData[DIV_W-1:0];
          cfg.ivs <= wrData[11];
          cfg.ihs <= wrData[12];
          cfg.ioe <= wrData[14];
          bypass  <= wrData[26];
        end
        default: begin
          enReg    <= wrData[0];
          cfg.dual <= wrData[1];
        end
      endcase
    end
  end

  assign tick     = enReg && (bypass || (divCnt == DC_W'(divSel) + DC_W'(1)));
  assign offWrite = wrEn && (wrAddr == 2'd3) && !wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (!enReg || tick) divCnt <= '0;
    else                    divCnt <= divCnt + DC_W'(1);
  end

  assign stb.tick  = tick;
  assign stb.clear = !enReg || offWrite;
  assign stb.run   = enReg;

endmodule

// File: rtl/lcdRasterPath.sv
module lcdRasterPath
  import lcdRasterPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  timingT         cfg,
  input  strobeT         stb,
  output logic [H_W-1:0] pixelCnt,
  output logic [V_W-1:0] lineCnt,
  output logic [V_W:0]   lowerLine,
  output logic           hSync,
  output logic           vSync,
  output logic           dataEn,
  output logic           frameStart
);
  logic [H_W-1:0] hCnt, hAct, hFpEnd, hSyEnd, hTot;
  logic [V_W-1:0] vCnt, vAct, vFpEnd, vSyEnd, vTot;
  logic           hLast, vLast;

  // Region boundaries, decoded from the stored fields
  assign hAct   = H_W'({cfg.ppl, 4'b0000}) + H_W'(16);
  assign hFpEnd = hAct   + H_W'(cfg.hfp) + H_W'(1);
  assign hSyEnd = hFpEnd + H_W'(cfg.hsw) + H_W'(1);
  assign hTot   = hSyEnd + H_W'(cfg.hbp) + H_W'(1);

  assign vAct   = V_W'(cfg.lpp) + V_W'(1);
  assign vFpEnd = vAct   + V_W'(cfg.vfp);
  assign vSyEnd = vFpEnd + V_W'(cfg.vsw) + V_W'(1);
  assign vTot   = vSyEnd + V_W'(cfg.vbp);

  assign hLast = (hCnt == hTot - H_W'(1));
  assign vLast = (vCnt == vTot - V_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (stb.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (stb.tick) begin
      if (hLast) begin
        hCnt <= '0;
        vCnt <= vLast ? '0 : vCnt + V_W'(1);
      end else begin
        hCnt <= hCnt + H_W'(1);
      end
    end
  end

  assign pixelCnt   = hCnt;
  assign lineCnt    = vCnt;
  assign lowerLine  = cfg.dual ? ({1'b0, vCnt} + {1'b0, vAct}) : {1'b0, vCnt};
  assign hSync      = (stb.run && hCnt >= hFpEnd && hCnt < hSyEnd) ^ cfg.ihs;
  assign vSync      = (stb.run && vCnt >= vFpEnd && vCnt < vSyEnd) ^ cfg.ivs;
  assign dataEn     = (stb.run && hCnt < hAct && vCnt < vAct) ^ cfg.ioe;
  assign frameStart = stb.run && (hCnt == '0) && (vCnt == '0);

endmodule

// File: rtl/lcdRasterGen.sv
module lcdRasterGen
  import lcdRasterPkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int DIV_W = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrAddr,
  input  logic [31:0]    wrData,
  output logic           pixClkEn,
  output logic           hSync,
  output logic           vSync,
  output logic           dataEn,
  output logic           frameStart,
  output logic [H_W-1:0] pixelCnt,
  output logic [V_W-1:0] lineCnt,
  output logic [V_W:0]   lowerLine
);
  timingT cfg;
  strobeT stb;

  lcdRasterCtrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .stb(stb)
  );

  lcdRasterPath #(.H_W(H_W), .V_W(V_W)) u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .pixelCnt(pixelCnt), .lineCnt(lineCnt), .lowerLine(lowerLine),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .frameStart(frameStart)
  );

  assign pixClkEn = stb.tick;

endmodule

// File: rtl/lcdRasterChk.sv
module lcdRasterChk #(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input logic           clk,
  input logic           rstN,
  input logic           offWrite,
  input logic           ctrlWrite,
  input logic           pixClkEn,
  input logic           frameStart,
  input logic [H_W-1:0] pixelCnt,
  input logic [V_W-1:0] lineCnt
);

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    offWrite |=> (pixelCnt == '0 && lineCnt == '0 && !frameStart && !pixClkEn));

  // R3
  pixel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pixClkEn && !ctrlWrite) |=> $stable(pixelCnt));

  // R7
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (pixelCnt == '0 && lineCnt == '0));

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineCnt != $past(lineCnt)) |-> (pixelCnt == '0));

endmodule

bind lcdRasterGen lcdRasterChk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .offWrite(wrEn && (wrAddr == 2'd3) && !wrData[0]),
  .ctrlWrite(wrEn && (wrAddr == 2'd3)),
  .pixClkEn(pixClkEn), .frameStart(frameStart),
  .pixelCnt(pixelCnt), .lineCnt(lineCnt)
);

// File: tb/lcdRasterGen_bench.sv
module lcdRasterGen_bench;
  localparam int H_W = 12;
  localparam int V_W = 12;

  logic           clk = 1'b0;
  logic           rstN;
  logic           wrEn;
  logic [1:0]     wrAddr;
  logic [31:0]    wrData;
  logic           pixClkEn, hSync, vSync, dataEn, frameStart;
  logic [H_W-1:0] pixelCnt;
  logic [V_W-1:0] lineCnt;
  logic [V_W:0]   lowerLine;

  always #4 clk = ~clk;

  lcdRasterGen #(.H_W(H_W), .V_W(V_W)) u_lcdRasterGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixClkEn(pixClkEn), .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .frameStart(frameStart), .pixelCnt(pixelCnt), .lineCnt(lineCnt),
    .lowerLine(lowerLine)
  );

  int total = 0;
  int bad   = 0;

  // current setup (stored field values)
  int ppl, hsw, hbp, hfp, lpp, vsw, vbp, vfp, pcd, byp, ivs, ihs, ioe, dual;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int aW();  return 16 * (ppl + 1); endfunction
  function automatic int hTotF(); return aW() + (hfp + 1) + (hsw + 1) + (hbp + 1); endfunction
  function automatic int vTotF(); return (lpp + 1) + vfp + (vsw + 1) + vbp; endfunction
  function automatic int divF(); return (byp != 0) ? 1 : pcd + 2; endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(addr); wrData = data;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic runSetup();
    int hT, vT, d, n;
    wr(3, 32'd0);
    wr(0, (32'(hfp) << 24) | (32'(hbp) << 16) | (32'(hsw) << 8) | (32'(ppl) << 2));
    wr(1, (32'(vfp) << 24) | (32'(vbp) << 16) | (32'(vsw) << 10) | 32'(lpp));
    wr(2, (32'(byp) << 26) | (32'(ioe) << 14) | (32'(ihs) << 12) | (32'(ivs) << 11) | 32'(pcd));
    wr(3, (32'(dual) << 1) | 32'd1);
    hT = hTotF(); vT = vTotF(); d = divF();
    n  = hT * vT * d + 40;
    for (int c = 0; c < n; c++) begin
      int p, h, v, a, l, hsE, vsE, deE;
      @(negedge clk);
      p = (c / d) % (hT * vT);
      h = p % hT;
      v = p / hT;
      a = aW();
      l = lpp + 1;
      hsE = ((h >= a + hfp + 1) && (h < a + hfp + hsw + 2)) ? 1 : 0;
      vsE = ((v >= l + vfp) && (v < l + vfp + vsw + 1)) ? 1 : 0;
      deE = ((h < a) && (v < l)) ? 1 : 0;
      chk("R2 pixClkEn", int'(pixClkEn), ((c % d) == d - 1) ? 1 : 0);
      chk("R3 pixelCnt", int'(pixelCnt), h);
      chk("R4 lineCnt", int'(lineCnt), v);
      chk("R5 hSync", int'(hSync), hsE ^ ihs);
      chk("R5 vSync", int'(vSync), vsE ^ ivs);
      chk("R6 dataEn", int'(dataEn), deE ^ ioe);
      chk("R7 frameStart", int'(frameStart), (h == 0 && v == 0) ? 1 : 0);
      chk("R9 lowerLine", int'(lowerLine), (dual != 0) ? v + l : v);
    end
    // mid-frame stop
    wr(3, 32'd0);
    @(negedge clk);
    chk("R8 stop pixelCnt", int'(pixelCnt), 0);
    chk("R8 stop lineCnt", int'(lineCnt), 0);
    chk("R8 stop pixClkEn", int'(pixClkEn), 0);
    chk("R8 stop frameStart", int'(frameStart), 0);
    chk("R8 stop hSync", int'(hSync), ihs);
    chk("R8 stop vSync", int'(vSync), ivs);
    chk("R8 stop dataEn", int'(dataEn), ioe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd2024));
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk("R1 pixClkEn", int'(pixClkEn), 0);
    chk("R1 hSync", int'(hSync), 0);
    chk("R1 vSync", int'(vSync), 0);
    chk("R1 dataEn", int'(dataEn), 0);
    chk("R1 frameStart", int'(frameStart), 0);
    chk("R1 pixelCnt", int'(pixelCnt), 0);
    chk("R1 lineCnt", int'(lineCnt), 0);
    chk("R1 lowerLine", int'(lowerLine), 0);

    // directed: bypass, true polarities, single panel, minimum porches
    ppl = 0; hsw = 5; hbp = 5; hfp = 5; lpp = 1; vsw = 0; vbp = 0; vfp = 0;
    pcd = 3; byp = 1; ivs = 0; ihs = 0; ioe = 0; dual = 0;
    runSetup();

    // directed: divided clock, all inverted, dual panel
    ppl = 1; hsw = 6; hbp = 9; hfp = 7; lpp = 3; vsw = 2; vbp = 3; vfp = 2;
    pcd = 2; byp = 0; ivs = 1; ihs = 1; ioe = 1; dual = 1;
    runSetup();

    for (int k = 0; k < 6; k++) begin
      ppl  = int'($urandom_range(1, 0));
      hsw  = int'($urandom_range(9, 5));
      hbp  = int'($urandom_range(9, 5));
      hfp  = int'($urandom_range(9, 5));
      lpp  = int'($urandom_range(4, 1));
      vsw  = int'($urandom_range(2, 0));
      vbp  = int'($urandom_range(3, 0));
      vfp  = int'($urandom_range(3, 0));
      pcd  = int'($urandom_range(2, 0));
      byp  = ($urandom_range(2, 0) == 0) ? 1 : 0;
      ivs  = int'($urandom_range(1, 0));
      ihs  = int'($urandom_range(1, 0));
      ioe  = int'($urandom_range(1, 0));
      dual = int'($urandom_range(1, 0));
      runSetup();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule